// File: doc/BRIEF.md
# DDR Late-Write Synchronous SRAM Core

This block models a synchronous static memory whose data path runs at double data rate. Commands and addresses are taken only on the rising clock edge. Every access moves one pair of half-words: one half in the high phase of a clock cycle and the other half in the low phase. The external address selects a pair. The lowest bit of the internal half-word index is never supplied from outside. The core generates it: 0 for the half that moves on the rising edge and 1 for the half that moves on the falling edge.

Writes use a late-write protocol. The write command and its address arrive in one cycle, and the two data halves follow in the next cycle. The array is updated on the rising edge after both halves have been captured, with no externally timed write strobe. Reads pass through a registered output stage and appear two rising edges after the command. A read that hits a write still waiting in the write pipeline returns the new data.

Two select inputs, each with a polarity fixed by a parameter, must both be at their active level for a command to count. A burst-continue command repeats the access of the previous cycle at the next pair address, so no new address has to be presented. The output-enable signal drops two cycles after a cycle that issues no read.

Top module: `ddrsram_core`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, all pipelines empty. On the cycles that follow, `q_drive` is 0 and `q` reads 0 until a read issued after reset reaches the outputs.
- R2: A command counts only when `sel_a` equals `SEL_A_ON` and `sel_b` equals `SEL_B_ON` at the rising edge. Any other combination is a deselect, and it changes neither memory contents nor outputs.
- R3: A write command (`op` = 2'b10) at edge k with pair address A stores the `d` value sampled at rising edge k+1 at half-word index {A,0}. It stores the `d` value sampled at the falling edge that follows edge k+1 at index {A,1}.
- R4: A read command (`op` = 2'b01) at edge k makes `q_drive` 1 for the cycle that begins at edge k+2. In that cycle `q` shows half {A,0} while `clk` is high and half {A,1} while `clk` is low.
- R5: A read of a pair whose write is still in the late-write pipeline returns the new data. This includes a read issued in the cycle right after the write command.
- R6: After a cycle with no accepted read, `q_drive` stays at its old value at the next rising edge and goes to 0 at the second rising edge.
- R7: A burst-continue command (`op` = 2'b11) repeats the previous cycle's accepted read or write at pair address previous+1, wrapping modulo 2^ADDR_W. If the previous cycle had no accepted access, including a reset cycle, it acts as a deselect.
- R8: Whenever `q_drive` is 0, `q` reads 0 in both clock phases.
- R9: Values on `d` in cycles that do not carry write data never reach the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Commands are taken on the rising edge; second data halves move on the falling edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_a | input | 1 | First select, active level set by SEL_A_ON |
| sel_b | input | 1 | Second select, active level set by SEL_B_ON |
| op | input | 2 | 00 idle, 01 read, 10 write, 11 burst continue |
| addr | input | ADDR_W | Pair address; the half-word bit is generated internally |
| d | input | HALF_W | Write data, one half-word per clock edge |
| q | output | HALF_W | Read data, one half-word per clock phase |
| q_drive | output | 1 | High for the cycle in which `q` carries read data |

## Verification
The bench builds the core with ADDR_W = 3 and HALF_W = 8, and with both select polarities inverted from their defaults (SEL_A_ON = 0, SEL_B_ON = 1). The inverted polarities show that the gating follows the parameters and not a fixed level. The eight-pair space lets a short burst run past the top address and wrap to pair 0, which is then read back while its write is still pending. Distinct data on every edge exposes any swap of the rising and falling halves, and exposes any write that captures the wrong cycle's data.

// File: rtl/ddrsram_pkg.sv
// Shared encodings for the DDR late-write SRAM core.
// Assumes a two-bit command field on the top-level port.
package ddrsram_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_NEXT  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RD   = 2'b01,
        ACC_WR   = 2'b10
    } acc_e;
endpackage

// File: rtl/ddrsram_cmd.sv
// Command stage: qualifies the command with both selects and resolves
// burst-continue into an explicit access at the next pair address.
// The result is registered on the rising edge. Assumes op and addr are
// stable around the rising edge.
module ddrsram_cmd
    import ddrsram_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter bit SEL_A_ON = 1'b1,
    parameter bit SEL_B_ON = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    output acc_e              kind_q,
    output logic [ADDR_W-1:0] addr_q
);
    logic              picked;
    acc_e              kind_d;
    logic [ADDR_W-1:0] addr_d;

    assign picked = (sel_a == SEL_A_ON) && (sel_b == SEL_B_ON);

    // Decode the command; burst-continue inherits the previous access.
    always_comb begin
        kind_d = ACC_NONE;
        addr_d = addr;
        if (picked) begin
            unique case (op_e'(op))
                OP_READ:  kind_d = ACC_RD;
                OP_WRITE: kind_d = ACC_WR;
                OP_NEXT: begin
                    kind_d = kind_q;
                    addr_d = addr_q + ADDR_W'(1);
                end
                default:  kind_d = ACC_NONE;
            endcase
        end
    end

    // Register the resolved access for the pipelines behind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= ACC_NONE;
            addr_q <= '0;
        end else begin
            kind_q <= kind_d;
            addr_q <= addr_d;
        end
    end

    assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_a != SEL_A_ON) || (sel_b != SEL_B_ON)) |=> (kind_q == ACC_NONE));

    assert_burst_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_a == SEL_A_ON) && (sel_b == SEL_B_ON) && (op == 2'b11) && (kind_q != ACC_NONE))
        |=> ((addr_q == $past(addr_q) + ADDR_W'(1)) && (kind_q == $past(kind_q))));
endmodule

// File: rtl/ddrsram_wpipe.sv
// Late-write pipeline: takes the address one cycle before the data.
// It captures the low half on the rising edge and the high half on the
// falling edge, then presents a complete pending pair for commit.
// Assumes wr_in and addr_in come from the registered command stage.
module ddrsram_wpipe #(
    parameter int ADDR_W = 4,
    parameter int HALF_W = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_in,
    input  logic [ADDR_W-1:0]      addr_in,
    input  logic [HALF_W-1:0]      d,
    output logic                   pend_v,
    output logic [ADDR_W-1:0]      pend_addr,
    output logic [1:0][HALF_W-1:0] pend_pair
);
    logic [HALF_W-1:0] half_lo;
    logic [HALF_W-1:0] half_hi;

    // Rising edge: move the write into the data phase and take the low half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            half_lo   <= '0;
        end else begin
            pend_v    <= wr_in;
            pend_addr <= addr_in;
            half_lo   <= d;
        end
    end

    // Falling edge: take the high half of the same pair.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            half_hi <= '0;
        end else begin
            half_hi <= d;
        end
    end

    assign pend_pair = {half_hi, half_lo};

    assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_in |=> !pend_v);
endmodule

// File: rtl/ddrsram_array.sv
// Storage array split into two banks, one per value of the internally
// generated half-word bit. A pending write at the read address is
// forwarded to the lookup so that reads stay coherent.
// Assumes at most one write is pending at the moment of any lookup.
module ddrsram_array #(
    parameter int ADDR_W = 4,
    parameter int HALF_W = 18
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [1:0][HALF_W-1:0] wr_pair,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [1:0][HALF_W-1:0] rd_pair
);
    localparam int PAIRS = 1 << ADDR_W;

    logic hit;
    assign hit = wr_en && (wr_addr == rd_addr);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [HALF_W-1:0] cells [PAIRS];

        // Commit this bank's half of a completed pair.
        always_ff @(posedge clk) begin
            if (wr_en) begin
                cells[wr_addr] <= wr_pair[b];
            end
        end

        assign rd_pair[b] = hit ? wr_pair[b] : cells[rd_addr];
    end
endmodule

// File: rtl/ddrsram_rpipe.sv
// Read pipeline: one lookup register, then a rising-edge output register
// for the low half and a falling-edge register for the high half.
// The output follows the clock phase. Assumes rd_in comes from the
// registered command stage.
module ddrsram_rpipe #(
    parameter int HALF_W = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_in,
    input  logic [1:0][HALF_W-1:0] pair_in,
    output logic [HALF_W-1:0]      q,
    output logic                   q_drive
);
    logic                   look_v;
    logic [1:0][HALF_W-1:0] look_pair;
    logic [HALF_W-1:0]      q_rise;
    logic [HALF_W-1:0]      hold_hi;
    logic [HALF_W-1:0]      q_fall;

    // Rising edge: register the lookup, then load the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            look_v    <= 1'b0;
            look_pair <= '0;
            q_drive   <= 1'b0;
            q_rise    <= '0;
            hold_hi   <= '0;
        end else begin
            look_v    <= rd_in;
            look_pair <= pair_in;
            q_drive   <= look_v;
            q_rise    <= look_v ? look_pair[0] : '0;
            hold_hi   <= look_v ? look_pair[1] : '0;
        end
    end

    // Falling edge: present the high half for the low clock phase.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            q_fall <= '0;
        end else begin
            q_fall <= hold_hi;
        end
    end

    assign q = clk ? q_rise : q_fall;

    assert_read_reaches_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_in |=> ##1 q_drive);

    assert_drive_off_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_in |=> ##1 !q_drive);
endmodule

// File: rtl/ddrsram_core.sv
// DDR late-write SRAM core top level. It joins the command stage, the
// write pipeline, the storage array and the read pipeline. Assumes a
// single clock; the falling edge carries the second half of each pair.
module ddrsram_core
    import ddrsram_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int HALF_W   = 18,
    parameter bit SEL_A_ON = 1'b1,
    parameter bit SEL_B_ON = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] d,
    output logic [HALF_W-1:0] q,
    output logic              q_drive
);
    acc_e                   acc_kind;
    logic [ADDR_W-1:0]      acc_addr;
    logic                   pend_v;
    logic [ADDR_W-1:0]      pend_addr;
    logic [1:0][HALF_W-1:0] pend_pair;
    logic [1:0][HALF_W-1:0] look_pair;
    logic                   wr_go;
    logic                   rd_go;

    assign wr_go = (acc_kind == ACC_WR);
    assign rd_go = (acc_kind == ACC_RD);

    ddrsram_cmd #(
        .ADDR_W  (ADDR_W),
        .SEL_A_ON(SEL_A_ON),
        .SEL_B_ON(SEL_B_ON)
    ) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_a (sel_a),
        .sel_b (sel_b),
        .op    (op),
        .addr  (addr),
        .kind_q(acc_kind),
        .addr_q(acc_addr)
    );

    ddrsram_wpipe #(
        .ADDR_W(ADDR_W),
        .HALF_W(HALF_W)
    ) u_wpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_in    (wr_go),
        .addr_in  (acc_addr),
        .d        (d),
        .pend_v   (pend_v),
        .pend_addr(pend_addr),
        .pend_pair(pend_pair)
    );

    ddrsram_array #(
        .ADDR_W(ADDR_W),
        .HALF_W(HALF_W)
    ) u_array (
        .clk    (clk),
        .wr_en  (pend_v),
        .wr_addr(pend_addr),
        .wr_pair(pend_pair),
        .rd_addr(acc_addr),
        .rd_pair(look_pair)
    );

    ddrsram_rpipe #(
        .HALF_W(HALF_W)
    ) u_rpipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_in  (rd_go),
        .pair_in(look_pair),
        .q      (q),
        .q_drive(q_drive)
    );

    assert_quiet_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q_drive |-> (q == '0));
endmodule

// File: tb/ddrsram_core_test.sv
// Self-checking bench: a table of commands walked by one loop against a
// reference pair memory, then directed reset and burst corner cases.
module ddrsram_core_test;
    localparam int AW = 3;
    localparam int HW = 8;
    localparam bit SA_ON = 1'b0;
    localparam bit SB_ON = 1'b1;
    localparam int N = 23;

    // Each entry is {op[1:0], addr[2:0], sel_a, sel_b}; selects 01 = accepted.
    localparam logic [6:0] VEC [0:N-1] = '{
        7'b10_000_01,  //  0 write pair 0 (R3)
        7'b11_000_01,  //  1 burst write pair 1 (R7)
        7'b11_000_01,  //  2 burst write pair 2 (R7)
        7'b01_000_01,  //  3 read pair 0
        7'b11_000_01,  //  4 burst read pair 1
        7'b11_000_01,  //  5 burst read pair 2
        7'b10_111_01,  //  6 write pair 7
        7'b11_000_01,  //  7 burst wraps to pair 0 (R7)
        7'b01_000_01,  //  8 read pair 0 while its write is pending (R5)
        7'b01_111_01,  //  9 read pair 7
        7'b00_000_01,  // 10 idle: output off two cycles later (R6)
        7'b11_000_01,  // 11 burst after idle is a deselect (R7)
        7'b10_001_11,  // 12 write with sel_a inactive is ignored (R2)
        7'b10_010_00,  // 13 write with sel_b inactive is ignored (R2)
        7'b01_001_01,  // 14 pair 1 still holds entry 1 data (R2)
        7'b01_010_01,  // 15 pair 2 still holds entry 2 data (R2)
        7'b10_100_01,  // 16 write pair 4
        7'b01_100_01,  // 17 read pair 4 in the next cycle (R5)
        7'b00_000_01,  // 18 idle while d keeps changing (R9)
        7'b01_100_01,  // 19 pair 4 unchanged by idle-cycle data (R9)
        7'b01_001_10,  // 20 read with both selects inactive (R2)
        7'b00_000_01,  // 21 idle
        7'b00_000_01   // 22 idle
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_a = ~SA_ON;
    logic          sel_b = ~SB_ON;
    logic [1:0]    op = 2'b00;
    logic [AW-1:0] addr = '0;
    logic [HW-1:0] d = '0;
    logic [HW-1:0] q;
    logic          q_drive;

    int total = 0;
    int bad = 0;
    int ecnt = 0;
    bit done = 1'b0;

    logic [1:0][HW-1:0] ref_mem [0:(1<<AW)-1];
    bit                 exp_rd [0:127];
    logic [1:0][HW-1:0] exp_v [0:127];
    int                 prev_kind = 0;
    logic [AW-1:0]      prev_a = '0;

    always #5 clk = ~clk;

    ddrsram_core #(
        .ADDR_W  (AW),
        .HALF_W  (HW),
        .SEL_A_ON(SA_ON),
        .SEL_B_ON(SB_ON)
    ) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .op     (op),
        .addr   (addr),
        .d      (d),
        .q      (q),
        .q_drive(q_drive)
    );

    function automatic logic [HW-1:0] f_lo(input int e);
        return HW'((e * 29 + 17) & 255);
    endfunction

    function automatic logic [HW-1:0] f_hi(input int e);
        return HW'((e * 53 + 101) & 255);
    endfunction

    task automatic chk(input string tag, input logic [HW-1:0] got, input logic [HW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s edge=%0d got=%h exp=%h", tag, ecnt - 1, got, exp);
        end
    endtask

    // Reference model of the command captured at edge e.
    task automatic model(input logic [1:0] o, input logic [AW-1:0] a,
                         input logic sa_i, input logic sb_i, input logic rs, input int e);
        int            kind;
        logic [AW-1:0] aa;
        exp_rd[e] = 1'b0;
        if (!rs) begin
            prev_kind = 0;
            if (e >= 1) exp_rd[e-1] = 1'b0;
            if (e >= 2) exp_rd[e-2] = 1'b0;
            return;
        end
        kind = 0;
        aa = a;
        if ((sa_i == SA_ON) && (sb_i == SB_ON)) begin
            case (o)
                2'b01: kind = 1;
                2'b10: kind = 2;
                2'b11: if (prev_kind != 0) begin
                    kind = prev_kind;
                    aa = prev_a + AW'(1);
                end
                default: kind = 0;
            endcase
        end
        if (kind == 2) ref_mem[aa] = {f_hi(e + 1), f_lo(e + 1)};
        if (kind == 1) begin
            exp_rd[e] = 1'b1;
            exp_v[e] = ref_mem[aa];
        end
        prev_kind = kind;
        prev_a = aa;
    endtask

    // Check one phase of the output slot that began at the last edge.
    task automatic look(input int beat, input string tag);
        int k;
        k = ecnt - 3;
        if (k >= 0 && exp_rd[k]) begin
            chk("R4 drive", HW'(q_drive), HW'(1));
            chk(beat == 0 ? "R4 low half" : "R3 high half", q, exp_v[k][beat]);
        end else begin
            chk(tag == "" ? "R6 drive off" : tag, HW'(q_drive), HW'(0));
            chk(tag == "" ? "R8 quiet q" : tag, q, HW'(0));
        end
    endtask

    // One clock cycle: the command for edge ecnt, data halves, two samples.
    task automatic tick(input logic [1:0] o, input logic [AW-1:0] a,
                        input logic sa_i, input logic sb_i, input logic rs, input string tag);
        model(o, a, sa_i, sb_i, rs, ecnt);
        #1;
        rst_n = rs;
        op = o;
        addr = a;
        sel_a = sa_i;
        sel_b = sb_i;
        d = f_hi(ecnt - 1);
        #2;
        look(0, tag);
        #3;
        d = f_lo(ecnt);
        #2;
        look(1, tag);
        @(posedge clk);
        ecnt++;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) exp_rd[i] = 1'b0;
        @(posedge clk);
        // R1: outputs quiet while reset is held
        for (int i = 0; i < 3; i++) tick(2'b00, '0, SA_ON, SB_ON, 1'b0, "R1 reset");
        for (int i = 0; i < N + 3; i++) begin
            logic [6:0] v;
            v = (i < N) ? VEC[i] : {2'b00, 3'b000, SA_ON, SB_ON};
            tick(v[6:5], v[4:2], v[1], v[0], 1'b1, "");
        end
        // R1: a read in flight is flushed by reset
        tick(2'b01, 3'd0, SA_ON, SB_ON, 1'b1, "");
        tick(2'b00, '0, SA_ON, SB_ON, 1'b0, "R1 flush");
        tick(2'b00, '0, SA_ON, SB_ON, 1'b0, "R1 flush");
        // R7: burst right after reset has no access to continue
        tick(2'b11, '0, SA_ON, SB_ON, 1'b1, "R1 flush");
        tick(2'b01, 3'd0, SA_ON, SB_ON, 1'b1, "R7 burst after reset");
        tick(2'b00, '0, SA_ON, SB_ON, 1'b1, "R7 burst after reset");
        tick(2'b00, '0, SA_ON, SB_ON, 1'b1, "");
        tick(2'b00, '0, SA_ON, SB_ON, 1'b1, "");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule